// File: doc/BRIEF.md
# Legacy UART Register Interface

This block is the byte-wide register front end of a classic PC-style serial port. A host reaches eight register offsets through a simple bus with an address, a read strobe, a write strobe, write data and combinational read data. Received bytes come in on a valid/ready stream. The byte at the head of that stream is the receive holding register. Bytes written to the data register leave on a one-cycle valid pulse. A single interrupt line reports pending transmit and receive events.

Most transmit and receive interrupts are not raised straight away. They are raised when a restartable delay timer expires. The delay is a parameter given in clock cycles. A receive interrupt is raised at once in one case only: a new byte appears while receive interrupts are enabled. The status registers are simplified. The transmitter always reads as empty. The modem control register has one loopback quirk. Divisor latches are decoded but store nothing. Scratch, FIFO control and modem status are stubs.

Top module: `legacy_uart_regs`

## Requirements
- R1: After reset, every register, both pending flags and both timers are cleared: irq and txValid are 0, offset 3 and offset 1 read 0x00, and offset 2 reads 0x01.
- R2: While LCR bit 7 is clear, offset 1 holds the interrupt enable byte. Offset 3 holds the line control byte. Both read back exactly the last value written.
- R3: While LCR bit 7 is set, offsets 0 and 1 read 0x00 and writes to them are ignored. This means no byte is sent, the enable byte keeps its value and no received byte is popped.
- R4: Offset 5 reads 0x60 (bit 6 transmitter empty, bit 5 holding register empty). It reads 0x61 when a received byte is waiting (bit 0 data ready).
- R5: Offset 2 reads 0x00 while any interrupt is pending and 0x01 while none is pending.
- R6: Writing offset 0 produces a one-cycle txValid pulse carrying the byte and clears the pending transmit flag. If enable bit 1 is set, the write also restarts the transmit timer.
- R7: Reading offset 0 returns the waiting byte and asserts rxReady in that cycle. With no byte waiting, the read returns 0x00. The read clears the pending receive flag. If enable bit 0 is set, it restarts the receive timer, and the receive interrupt is posted when that timer expires provided a byte is waiting.
- R8: Writing the enable byte with bit 1 set starts the transmit timer. Writing it with bit 1 clear cancels that timer and clears the pending transmit flag.
- R9: Writing the enable byte with bit 0 set starts the receive timer only when a byte is waiting. Otherwise the write cancels that timer and clears the pending receive flag.
- R10: A timer posts its interrupt exactly DELAY cycles after the edge that started it, only if its enable is still set. Restarting a running timer reloads the full delay.
- R11: When rxValid rises while enable bit 0 is set, the receive interrupt is posted at the next clock edge. When the enable is clear, nothing is posted.
- R12: Offsets 4, 6 and 7 read 0x00. Writes to offsets 2, 6 and 7 change no state. Writing 0x1A to offset 4 makes the modem control register hold 0x9A.
- R13: irq is high whenever the transmit flag or the receive flag is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while busRd is high |
| rxValid | input | 1 | A received byte is waiting |
| rxData | input | 8 | The waiting received byte |
| rxReady | output | 1 | Pops the waiting byte |
| txValid | output | 1 | One-cycle pulse for a sent byte |
| txData | output | 8 | Sent byte |
| irq | output | 1 | Interrupt request |

## Verification
The timers are started in several ways: by an enable write, by a data write, by a data read while a next byte is waiting, and by a second enable write partway through a countdown. Checks land one cycle before and exactly at the expected expiry, which separates an off-by-one count, a missing reload and a timer that never stops. Receive traffic is run in three cases: a byte arriving while enabled, a byte arriving while disabled and enabled later, and a pop that either leaves a byte waiting or drains the stream. These cases separate the immediate post, the delayed post and the expiry-time data check. The divisor-latch and stub offsets are written with nonzero values and the live registers are read back afterwards, which exposes any decode that leaks into real state.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;

  localparam int LCTL_LATCH_BIT = 7;
  localparam int IEN_RX_BIT     = 0;
  localparam int IEN_TX_BIT     = 1;

  localparam logic [DATA_W-1:0] MCTL_LOOP_KEY = 8'h1A;
  localparam logic [DATA_W-1:0] MCTL_LOOP_VAL = 8'h9A;
  localparam logic [DATA_W-1:0] LSTS_IDLE     = 8'h60;

  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic wrLctl;
    logic wrIen;
    logic wrMctl;
    logic sendTx;
    logic popRx;
  } frontStrobe_t;
endpackage

// File: rtl/uart_front_ctl.sv
module uart_front_ctl
  import uart_front_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dlab,
  output frontStrobe_t      strb
);
  logic liveLow;

  // offsets 0 and 1 reach live registers only while the latch bit is clear
  assign liveLow = !dlab;

  always_comb begin
    strb        = '0;
    strb.wrLctl = busWr && (busAddr == OFS_LCTL);
    strb.wrMctl = busWr && (busAddr == OFS_MCTL);
    strb.wrIen  = busWr && (busAddr == OFS_IEN)  && liveLow;
    strb.sendTx = busWr && (busAddr == OFS_DATA) && liveLow;
    strb.popRx  = busRd && (busAddr == OFS_DATA) && liveLow;
  end
endmodule

// File: rtl/uart_front_timer.sv
module uart_front_timer #(
  parameter int DELAY = 45
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic cancel,
  output logic expire
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt;
  logic          running;

  assign expire = running && (cnt == ONE) && !load && !cancel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (cancel) begin
      running <= 1'b0;
    end else if (load) begin
      cnt     <= LOAD_VAL;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == ONE) running <= 1'b0;
      else            cnt     <= cnt - ONE;
    end
  end
endmodule

// File: rtl/uart_front_irq.sv
module uart_front_irq
  import uart_front_pkg::*;
#(
  parameter int DELAY = 45
) (
  input  logic         clk,
  input  logic         rstN,
  input  frontStrobe_t strb,
  input  logic [1:0]   wrBits,
  input  logic [1:0]   ienEn,
  input  logic         rxValid,
  output logic         pendTx,
  output logic         pendRx,
  output logic         irq
);
  logic [NUM_CH-1:0] ld, cn, ex, setP, clrP, pend;
  logic rxSeen;
  logic rxArrive;

  assign rxArrive = rxValid && !rxSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSeen <= 1'b0;
    else       rxSeen <= rxValid;
  end

  always_comb begin
    ld[CH_TX]   = (strb.sendTx && ienEn[IEN_TX_BIT]) || (strb.wrIen && wrBits[IEN_TX_BIT]);
    cn[CH_TX]   = strb.wrIen && !wrBits[IEN_TX_BIT];
    clrP[CH_TX] = strb.sendTx || cn[CH_TX];
    setP[CH_TX] = ex[CH_TX] && ienEn[IEN_TX_BIT];

    ld[CH_RX]   = (strb.popRx && ienEn[IEN_RX_BIT]) ||
                  (strb.wrIen && wrBits[IEN_RX_BIT] && rxValid);
    cn[CH_RX]   = strb.wrIen && !(wrBits[IEN_RX_BIT] && rxValid);
    clrP[CH_RX] = strb.popRx || cn[CH_RX];
    setP[CH_RX] = (ex[CH_RX] && ienEn[IEN_RX_BIT] && rxValid) ||
                  (rxArrive && ienEn[IEN_RX_BIT]);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic pendQ;

    uart_front_timer #(.DELAY(DELAY)) u_timer (
      .clk    (clk),
      .rstN   (rstN),
      .load   (ld[ch]),
      .cancel (cn[ch]),
      .expire (ex[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         pendQ <= 1'b0;
      else if (clrP[ch]) pendQ <= 1'b0;
      else if (setP[ch]) pendQ <= 1'b1;
    end

    assign pend[ch] = pendQ;
  end

  assign pendTx = pend[CH_TX];
  assign pendRx = pend[CH_RX];
  assign irq    = |pend;
endmodule

// File: rtl/uart_front_dp.sv
module uart_front_dp
  import uart_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  frontStrobe_t      strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              irqAny,
  output logic [DATA_W-1:0] busRdata,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] lctlQ,
  output logic [DATA_W-1:0] ienQ
);
  logic [DATA_W-1:0] mctlQ;
  logic [DATA_W-1:0] rdMux;
  logic              dlab;

  assign dlab    = lctlQ[LCTL_LATCH_BIT];
  assign rxReady = strb.popRx && rxValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lctlQ   <= '0;
      ienQ    <= '0;
      mctlQ   <= '0;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      if (strb.wrLctl) lctlQ <= busWdata;
      if (strb.wrIen)  ienQ  <= busWdata;
      if (strb.wrMctl && (busWdata == MCTL_LOOP_KEY)) mctlQ <= MCTL_LOOP_VAL;
      txValid <= strb.sendTx;
      if (strb.sendTx) txData <= busWdata;
    end
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      OFS_DATA: rdMux = (!dlab && rxValid) ? rxData : '0;
      OFS_IEN:  rdMux = dlab ? '0 : ienQ;
      OFS_IID:  rdMux = {{(DATA_W-1){1'b0}}, !irqAny};
      OFS_LCTL: rdMux = lctlQ;
      OFS_LSTS: rdMux = LSTS_IDLE | {{(DATA_W-1){1'b0}}, rxValid};
      default:  rdMux = '0;
    endcase
  end

  assign busRdata = busRd ? rdMux : '0;
endmodule

// File: rtl/legacy_uart_regs.sv
module legacy_uart_regs
  import uart_front_pkg::*;
#(
  parameter int DELAY = 45
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);
  frontStrobe_t      strb;
  logic [DATA_W-1:0] lctlQ;
  logic [DATA_W-1:0] ienQ;
  logic [1:0]        ienEn;
  logic              dlab;
  logic              pendTx;
  logic              pendRx;

  assign dlab  = lctlQ[LCTL_LATCH_BIT];
  assign ienEn = ienQ[1:0];

  uart_front_ctl u_ctl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .dlab    (dlab),
    .strb    (strb)
  );

  uart_front_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .irqAny   (irq),
    .busRdata (busRdata),
    .rxReady  (rxReady),
    .txValid  (txValid),
    .txData   (txData),
    .lctlQ    (lctlQ),
    .ienQ     (ienQ)
  );

  uart_front_irq #(.DELAY(DELAY)) u_irq (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (busWdata[1:0]),
    .ienEn   (ienEn),
    .rxValid (rxValid),
    .pendTx  (pendTx),
    .pendRx  (pendRx),
    .irq     (irq)
  );
endmodule

// File: rtl/legacy_uart_regs_chk.sv
module legacy_uart_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic       busRd,
  input logic       busWr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       rxValid,
  input logic       rxReady,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       irq,
  input logic       dlab,
  input logic [1:0] ienEn,
  input logic       pendTx,
  input logic       pendRx
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) $rose(rstN) |-> !irq && !txValid);

  assert_latch_no_send_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd0 && dlab) |=> !txValid);

  assert_latch_no_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd0 && dlab) |-> !rxReady);

  assert_status_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd5) |-> busRdata == {7'b0110000, rxValid});

  assert_ident_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd2) |-> busRdata == {7'b0, !irq});

  assert_send_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd0 && !dlab) |=> txValid && txData == $past(busWdata) && !pendTx);

  assert_pop_needs_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> rxValid && busRd);

  assert_tx_cancel_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd1 && !dlab && !busWdata[1]) |=> !pendTx);

  assert_arrival_post_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxValid) && ienEn[0] && !busWr && !busRd) |=> pendRx);

  assert_irq_follows_flags_R13: assert property (@(posedge clk) disable iff (!rstN)
    (pendTx || pendRx) |-> irq);
endmodule

module legacy_uart_mctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mctlWr,
  input logic [7:0] busWdata,
  input logic [7:0] mctlQ
);
  assert_loop_key_R12: assert property (@(posedge clk) disable iff (!rstN)
    (mctlWr && busWdata == 8'h1A) |=> mctlQ == 8'h9A);
endmodule

bind legacy_uart_regs legacy_uart_regs_chk u_chk (.*);
bind uart_front_dp legacy_uart_mctl_chk u_mctl_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mctlWr   (strb.wrMctl),
  .busWdata (busWdata),
  .mctlQ    (mctlQ)
);

// File: tb/tb_legacy_uart_regs.sv
`timescale 1ns/1ps
module tb_legacy_uart_regs;
  localparam int D = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxReady;
  logic       txValid;
  logic [7:0] txData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;
  logic       rdy;

  always #5 clk = ~clk;

  legacy_uart_regs #(.DELAY(D)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txValid(txValid), .txData(txData), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d, output logic r);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdata; r = rxReady;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // irq must stay low for D-1 cycles after the starting edge and rise at D
  task automatic expectExpiry(input string req);
    waitCyc(D - 1);
    chk(req, "irq one cycle before expiry", {7'b0, irq}, 8'h00);
    waitCyc(1);
    chk(req, "irq at expiry", {7'b0, irq}, 8'h01);
  endtask

  task automatic testReset;
    chk("R1", "irq after reset", {7'b0, irq}, 8'h00);
    chk("R1", "txValid after reset", {7'b0, txValid}, 8'h00);
    busRead(3'd2, rd, rdy); chk("R1", "ident after reset", rd, 8'h01);
    busRead(3'd3, rd, rdy); chk("R1", "line control after reset", rd, 8'h00);
    busRead(3'd1, rd, rdy); chk("R1", "enable after reset", rd, 8'h00);
    busRead(3'd5, rd, rdy); chk("R4", "status empty", rd, 8'h60);
  endtask

  task automatic testRegs;
    busWrite(3'd3, 8'h03); busRead(3'd3, rd, rdy); chk("R2", "line control readback", rd, 8'h03);
    busWrite(3'd1, 8'h0C); busRead(3'd1, rd, rdy); chk("R2", "enable readback", rd, 8'h0C);
    waitCyc(D + 2);
    chk("R10", "no enable bits no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic testLatch;
    busWrite(3'd3, 8'h83);
    busWrite(3'd0, 8'h77);
    chk("R3", "no send while latch bit set", {7'b0, txValid}, 8'h00);
    busWrite(3'd1, 8'h03);
    busRead(3'd1, rd, rdy); chk("R3", "offset 1 reads zero", rd, 8'h00);
    @(negedge clk); rxValid = 1'b1; rxData = 8'h42;
    busRead(3'd0, rd, rdy);
    chk("R3", "offset 0 reads zero", rd, 8'h00);
    chk("R3", "no pop while latch bit set", {7'b0, rdy}, 8'h00);
    busRead(3'd3, rd, rdy); chk("R2", "line control with latch bit", rd, 8'h83);
    busWrite(3'd3, 8'h03);
    busRead(3'd1, rd, rdy); chk("R3", "enable unchanged by latched write", rd, 8'h0C);
    busRead(3'd5, rd, rdy); chk("R4", "status byte waiting", rd, 8'h61);
    busRead(3'd0, rd, rdy);
    chk("R7", "pop returns byte", rd, 8'h42);
    chk("R7", "pop asserts rxReady", {7'b0, rdy}, 8'h01);
    rxValid = 1'b0;
    busWrite(3'd1, 8'h00);
  endtask

  task automatic testTx;
    busWrite(3'd1, 8'h02);
    expectExpiry("R8");
    busRead(3'd2, rd, rdy); chk("R5", "ident pending", rd, 8'h00);
    busWrite(3'd0, 8'h5A);
    chk("R6", "txValid pulse", {7'b0, txValid}, 8'h01);
    chk("R6", "tx byte", txData, 8'h5A);
    chk("R6", "send clears pending", {7'b0, irq}, 8'h00);
    waitCyc(1);
    chk("R6", "txValid one cycle", {7'b0, txValid}, 8'h00);
    waitCyc(D - 2);
    chk("R6", "restart not early", {7'b0, irq}, 8'h00);
    waitCyc(1);
    chk("R6", "restart posts", {7'b0, irq}, 8'h01);
    busWrite(3'd1, 8'h00);
    chk("R8", "disable clears pending", {7'b0, irq}, 8'h00);
    busWrite(3'd0, 8'hA5);
    chk("R6", "tx byte while disabled", txData, 8'hA5);
    waitCyc(D + 2);
    chk("R6", "no restart while disabled", {7'b0, irq}, 8'h00);
    busRead(3'd2, rd, rdy); chk("R5", "ident idle", rd, 8'h01);
  endtask

  task automatic testReloadCancel;
    busWrite(3'd1, 8'h02);
    waitCyc(5);
    busWrite(3'd1, 8'h02);
    expectExpiry("R10");
    busWrite(3'd1, 8'h00);
    busWrite(3'd1, 8'h02);
    waitCyc(3);
    busWrite(3'd1, 8'h00);
    waitCyc(D + 2);
    chk("R10", "cancelled timer never posts", {7'b0, irq}, 8'h00);
  endtask

  task automatic testRx;
    busWrite(3'd1, 8'h01);
    waitCyc(D + 2);
    chk("R9", "no data no timer", {7'b0, irq}, 8'h00);
    @(negedge clk); rxValid = 1'b1; rxData = 8'h31;
    waitCyc(1);
    chk("R11", "arrival posts at once", {7'b0, irq}, 8'h01);
    busRead(3'd0, rd, rdy);
    chk("R7", "pop byte", rd, 8'h31);
    chk("R7", "pop ready", {7'b0, rdy}, 8'h01);
    rxData = 8'h32;
    chk("R7", "pop clears pending", {7'b0, irq}, 8'h00);
    expectExpiry("R7");
    busRead(3'd0, rd, rdy);
    chk("R7", "second byte", rd, 8'h32);
    rxValid = 1'b0;
    waitCyc(D + 2);
    chk("R7", "drained stream stays quiet", {7'b0, irq}, 8'h00);
    busRead(3'd0, rd, rdy);
    chk("R7", "empty read zero", rd, 8'h00);
    chk("R7", "empty read no ready", {7'b0, rdy}, 8'h00);
    busWrite(3'd1, 8'h00);
  endtask

  task automatic testLateEnable;
    @(negedge clk); rxValid = 1'b1; rxData = 8'h44;
    waitCyc(3);
    chk("R11", "arrival while disabled", {7'b0, irq}, 8'h00);
    busWrite(3'd1, 8'h01);
    chk("R9", "enable with data not immediate", {7'b0, irq}, 8'h00);
    expectExpiry("R9");
    busWrite(3'd1, 8'h00);
    chk("R9", "disable clears rx pending", {7'b0, irq}, 8'h00);
    busWrite(3'd1, 8'h03);
    waitCyc(D);
    busWrite(3'd0, 8'h11);
    chk("R13", "rx flag keeps irq", {7'b0, irq}, 8'h01);
    busRead(3'd0, rd, rdy);
    rxValid = 1'b0;
    chk("R13", "both flags clear", {7'b0, irq}, 8'h00);
    waitCyc(D);
    chk("R13", "tx flag alone", {7'b0, irq}, 8'h01);
    busWrite(3'd1, 8'h00);
  endtask

  task automatic testStubs;
    busWrite(3'd7, 8'h55);
    busWrite(3'd2, 8'hC7);
    busWrite(3'd6, 8'hFF);
    busWrite(3'd4, 8'h1A);
    busRead(3'd7, rd, rdy); chk("R12", "scratch reads zero", rd, 8'h00);
    busRead(3'd4, rd, rdy); chk("R12", "modem control reads zero", rd, 8'h00);
    busRead(3'd6, rd, rdy); chk("R12", "modem status reads zero", rd, 8'h00);
    busRead(3'd3, rd, rdy); chk("R12", "line control untouched", rd, 8'h03);
    busRead(3'd1, rd, rdy); chk("R12", "enable untouched", rd, 8'h00);
    busRead(3'd2, rd, rdy); chk("R12", "ident untouched", rd, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testRegs();
    testLatch();
    testTx();
    testReloadCancel();
    testRx();
    testLateEnable();
    testStubs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule